// File: doc/BRIEF.md
# Conductance Neuron Step Engine

This block moves one integrate-and-fire neuron forward by a single simulation time step. When the synapse column that feeds it has finished summing, a controller pulses `start` and presents the excitatory sum, the inhibitory sum and an external input current. The block then works through a fixed sequence on one time-shared Q8.8 multiplier. First it adds each synaptic sum to its conductance and decays the result with that conductance's own precomputed factor. Next it forms the steady-state potential from a gain and the net drive. It then moves the membrane potential toward the steady-state value by a precomputed voltage decay factor, and finally compares the new potential against the neuron's own threshold.

A firing neuron raises `spike` together with its `done` pulse. Its potential is set to a programmable reset level, and a programmable refractory count begins. While that count is nonzero, a step only decays the conductances. A controller that collects the `done` pulses of many such units knows when every neuron has finished the step. All neuron constants are loaded through a small write port before the run.

Top module: `nrn_update_unit`

## Requirements
- R1: After synchronous reset the potential, both conductances, all constants and the refractory count are zero, and `busy`, `done` and `spike` are low.
- R2: While idle, `cfg_we` writes `cfg_data` into the entry chosen by `cfg_sel`: 0 threshold, 1 reset potential, 2 resting potential, 3 gain, 4 bias, 5 excitatory decay, 6 inhibitory decay, 7 voltage decay, 8 refractory length (low bits), 9 membrane potential. Writes made while `busy` is high are ignored.
- R3: Each step sets the excitatory conductance to mul(sat(gex + syn_ex), excitatory decay), and sets the inhibitory conductance to mul(sat(gin + syn_in), inhibitory decay).
- R4: All values are signed Q8.8. mul(a,b) adds 128 to the 32-bit product, shifts it arithmetically right by 8 and saturates to [-32768, 32767]. Sums saturate to the same range.
- R5: The steady-state potential is sat(rest + mul(gain, sat(gex - gin + ext_in + bias))), using the new conductances.
- R6: The new potential is sat(vinf + mul(sat(v - vinf), voltage decay)).
- R7: If the new potential is strictly greater than the threshold (signed compare), `spike` is high in the `done` cycle, the potential becomes the reset potential, and the refractory count is loaded with the refractory length. Otherwise the potential takes the new value.
- R8: A step that starts with a nonzero refractory count updates only the conductances. It leaves the potential unchanged, keeps `spike` low, decrements the count, and raises `done` 3 cycles after the start edge.
- R9: A `start` seen while idle makes `busy` high from the next cycle. On a normal step, `done` is a single-cycle pulse in the 6th cycle after the start edge, and `busy` falls in the cycle after `done`.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The step in progress finishes unchanged, and no second step follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Constant write strobe |
| cfg_sel | input | 4 | Constant select code |
| cfg_data | input | 16 | Constant value, Q8.8 or count |
| start | input | 1 | Begin one time step |
| syn_ex | input | 16 | Excitatory synaptic sum, Q8.8 |
| syn_in | input | 16 | Inhibitory synaptic sum, Q8.8 |
| ext_in | input | 16 | External input current, Q8.8 |
| busy | output | 1 | Step in progress |
| done | output | 1 | Step complete pulse |
| spike | output | 1 | Neuron fired this step, valid with done |
| v_out | output | 16 | Membrane potential, Q8.8 |
| g_ex_out | output | 16 | Excitatory conductance, Q8.8 |
| g_in_out | output | 16 | Inhibitory conductance, Q8.8 |

## Verification
The start edge loads the operands. A normal step then spends one cycle on each multiplier pass and one cycle on the compare, so `done` and `spike` are due in the 6th cycle after the start edge; a refractory step skips the steady-state and relaxation passes and finishes in the 3rd. The bench releases `start` one falling edge after asserting it and counts falling edges until `done`, comparing the count with the latency the model predicts. It reads the potential and both conductances in that same `done` cycle and checks in the next cycle that `done` and `busy` have dropped. Start pulses and constant writes injected mid-step land while the second multiplier pass is running, and their lack of effect is judged from the outputs of that step and the following one.

// File: rtl/nrn_pkg.sv
package nrn_pkg;

    parameter int unsigned QW   = 16;
    parameter int unsigned FRAC = 8;
    localparam int unsigned WW  = 2 * QW + 1;

    typedef logic signed [QW-1:0] q_t;
    typedef logic signed [WW-1:0] wide_t;

    localparam q_t Q_MAX = {1'b0, {(QW-1){1'b1}}};
    localparam q_t Q_MIN = {1'b1, {(QW-1){1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEC_EX, ST_DEC_IN, ST_GAIN, ST_RELAX, ST_CMP, ST_FIN
    } step_st_e;

    typedef enum logic [3:0] {
        SEL_THR    = 4'd0,
        SEL_VRESET = 4'd1,
        SEL_VREST  = 4'd2,
        SEL_GAIN   = 4'd3,
        SEL_BIAS   = 4'd4,
        SEL_DEX    = 4'd5,
        SEL_DIN    = 4'd6,
        SEL_DV     = 4'd7,
        SEL_REFR   = 4'd8,
        SEL_VMEM   = 4'd9
    } cfg_sel_e;

    typedef struct packed {
        q_t thr;
        q_t v_reset;
        q_t v_rest;
        q_t gain;
        q_t bias;
        q_t dec_ex;
        q_t dec_in;
        q_t dec_v;
    } nrn_cfg_t;

    function automatic q_t sat_w(input wide_t x);
        if ((&x[WW-1:QW-1]) || (~|x[WW-1:QW-1]))
            return x[QW-1:0];
        else if (x[WW-1])
            return Q_MIN;
        else
            return Q_MAX;
    endfunction

    function automatic q_t add_q(input q_t a, input q_t b);
        wide_t s;
        s = a;
        s = s + b;
        return sat_w(s);
    endfunction

    function automatic q_t sub_q(input q_t a, input q_t b);
        wide_t s;
        s = a;
        s = s - b;
        return sat_w(s);
    endfunction

    function automatic q_t drive_q(input q_t gex, input q_t gin,
                                   input q_t ext, input q_t bias);
        wide_t s;
        s = gex;
        s = s - gin + ext + bias;
        return sat_w(s);
    endfunction

    function automatic q_t mul_q(input q_t a, input q_t b);
        wide_t p;
        p = a;
        p = p * b;
        p = p + (1 <<< (FRAC - 1));
        p = p >>> FRAC;
        return sat_w(p);
    endfunction

endpackage

// File: rtl/nrn_cfg_regs.sv
module nrn_cfg_regs
    import nrn_pkg::*;
#(
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3:0]    sel,
    input  q_t            data,
    output nrn_cfg_t      cfg,
    output logic [RW-1:0] refr_len,
    output logic          vmem_wr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            refr_len <= '0;
        end else if (we) begin
            case (sel)
                SEL_THR:    cfg.thr     <= data;
                SEL_VRESET: cfg.v_reset <= data;
                SEL_VREST:  cfg.v_rest  <= data;
                SEL_GAIN:   cfg.gain    <= data;
                SEL_BIAS:   cfg.bias    <= data;
                SEL_DEX:    cfg.dec_ex  <= data;
                SEL_DIN:    cfg.dec_in  <= data;
                SEL_DV:     cfg.dec_v   <= data;
                SEL_REFR:   refr_len    <= data[RW-1:0];
                default: ;
            endcase
        end
    end

    assign vmem_wr = we && (sel == SEL_VMEM);

endmodule

// File: rtl/nrn_qmul.sv
module nrn_qmul
    import nrn_pkg::*;
(
    input  q_t a,
    input  q_t b,
    output q_t y
);

    assign y = mul_q(a, b);

endmodule

// File: rtl/nrn_seq.sv
module nrn_seq
    import nrn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     in_refr,
    output step_st_e st,
    output logic     busy,
    output logic     done
);

    step_st_e st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:   if (start) st_nx = ST_DEC_EX;
            ST_DEC_EX: st_nx = ST_DEC_IN;
            ST_DEC_IN: st_nx = in_refr ? ST_FIN : ST_GAIN;
            ST_GAIN:   st_nx = ST_RELAX;
            ST_RELAX:  st_nx = ST_CMP;
            ST_CMP:    st_nx = ST_FIN;
            ST_FIN:    st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign busy = (st != ST_IDLE);
    assign done = (st == ST_FIN);

endmodule

// File: rtl/nrn_update_unit.sv
module nrn_update_unit
    import nrn_pkg::*;
#(
    parameter int unsigned RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_sel,
    input  logic [QW-1:0] cfg_data,
    input  logic          start,
    input  logic [QW-1:0] syn_ex,
    input  logic [QW-1:0] syn_in,
    input  logic [QW-1:0] ext_in,
    output logic          busy,
    output logic          done,
    output logic          spike,
    output logic [QW-1:0] v_out,
    output logic [QW-1:0] g_ex_out,
    output logic [QW-1:0] g_in_out
);

    nrn_cfg_t      cfg_q;
    logic [RW-1:0] refr_len;
    logic          vmem_wr;
    step_st_e      st;
    logic          in_refr;

    q_t gex, gin, v, vinf, vnew, ex_sum, in_sum, ext_r;
    q_t mul_a, mul_b, prod;
    logic [RW-1:0] refr_cnt;
    logic          spike_r;
    logic          accept;

    assign accept = start && !busy;

    nrn_cfg_regs #(.RW(RW)) i_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we && !busy),
        .sel      (cfg_sel),
        .data     (q_t'(cfg_data)),
        .cfg      (cfg_q),
        .refr_len (refr_len),
        .vmem_wr  (vmem_wr)
    );

    nrn_seq i_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .in_refr (in_refr),
        .st      (st),
        .busy    (busy),
        .done    (done)
    );

    always_comb begin
        mul_a = '0;
        mul_b = '0;
        case (st)
            ST_DEC_EX: begin mul_a = ex_sum;            mul_b = cfg_q.dec_ex; end
            ST_DEC_IN: begin mul_a = in_sum;            mul_b = cfg_q.dec_in; end
            ST_GAIN:   begin mul_a = cfg_q.gain;
                             mul_b = drive_q(gex, gin, ext_r, cfg_q.bias); end
            ST_RELAX:  begin mul_a = sub_q(v, vinf);    mul_b = cfg_q.dec_v;  end
            default: ;
        endcase
    end

    nrn_qmul i_mul (
        .a (mul_a),
        .b (mul_b),
        .y (prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gex      <= '0;
            gin      <= '0;
            v        <= '0;
            vinf     <= '0;
            vnew     <= '0;
            ex_sum   <= '0;
            in_sum   <= '0;
            ext_r    <= '0;
            refr_cnt <= '0;
            spike_r  <= 1'b0;
            in_refr  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (vmem_wr) v <= q_t'(cfg_data);
                    if (accept) begin
                        ex_sum  <= add_q(gex, q_t'(syn_ex));
                        in_sum  <= add_q(gin, q_t'(syn_in));
                        ext_r   <= q_t'(ext_in);
                        in_refr <= (refr_cnt != '0);
                        spike_r <= 1'b0;
                    end
                end
                ST_DEC_EX: gex <= prod;
                ST_DEC_IN: begin
                    gin <= prod;
                    if (in_refr) refr_cnt <= refr_cnt - 1'b1;
                end
                ST_GAIN:  vinf <= add_q(cfg_q.v_rest, prod);
                ST_RELAX: vnew <= add_q(vinf, prod);
                ST_CMP: begin
                    if (vnew > cfg_q.thr) begin
                        v        <= cfg_q.v_reset;
                        refr_cnt <= refr_len;
                        spike_r  <= 1'b1;
                    end else begin
                        v <= vnew;
                    end
                end
                default: ;
            endcase
        end
    end

    assign spike    = done && spike_r;
    assign v_out    = v;
    assign g_ex_out = gex;
    assign g_in_out = gin;

endmodule

// File: rtl/nrn_update_chk.sv
module nrn_update_chk
    import nrn_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic spike,
    input logic in_refr,
    input q_t   v_out,
    input q_t   v_reset,
    input q_t   thr
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_spike_in_done_R7: assert property (@(posedge clk) disable iff (rst)
        spike |-> done);

    assert_spike_sets_reset_R7: assert property (@(posedge clk) disable iff (rst)
        spike |-> (v_out == v_reset));

    assert_refr_no_spike_R8: assert property (@(posedge clk) disable iff (rst)
        (done && in_refr) |-> !spike);

    assert_cfg_hold_busy_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(thr));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

bind nrn_update_unit nrn_update_chk i_nrn_update_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .spike   (spike),
    .in_refr (in_refr),
    .v_out   (q_t'(v_out)),
    .v_reset (cfg_q.v_reset),
    .thr     (cfg_q.thr)
);

// File: tb/test_nrn_update_unit.sv
module test_nrn_update_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        start = 1'b0;
    logic [15:0] syn_ex = '0, syn_in = '0, ext_in = '0;
    logic        busy, done, spike;
    logic [15:0] v_out, g_ex_out, g_in_out;

    int n_checks = 0;
    int n_errors = 0;

    int p_thr, p_vreset, p_vrest, p_gain, p_bias, p_dex, p_din, p_dv, p_refr;
    int m_gex, m_gin, m_v, m_refr, e_spk, e_lat;

    always #5 clk = ~clk;

    nrn_update_unit i_nrn_update_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .start(start), .syn_ex(syn_ex), .syn_in(syn_in), .ext_in(ext_in),
        .busy(busy), .done(done), .spike(spike), .v_out(v_out),
        .g_ex_out(g_ex_out), .g_in_out(g_in_out)
    );

    // stimulus: {syn_ex, syn_in, ext_in}; expected results come from the model
    localparam logic [47:0] STIM [8] = '{
        {16'h0100, 16'h0000, 16'h0000},
        {16'h0200, 16'h0040, 16'h0000},
        {16'h0000, 16'h0100, 16'h0080},
        {16'h0300, 16'h0000, 16'h0100},
        {16'h0100, 16'h0000, 16'h0000},
        {16'h0000, 16'h0000, 16'h0000},
        {16'hFF00, 16'h0000, 16'hFF80},
        {16'h0400, 16'h0000, 16'h0200}
    };

    function automatic int sat(input int x);
        if (x > 32767)  return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int mulq(input int a, input int b);
        int p;
        p = a * b + 128;
        return sat(p >>> 8);
    endfunction

    function automatic int s16(input logic [15:0] x);
        return int'($signed(x));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        p_thr = 0; p_vreset = 0; p_vrest = 0; p_gain = 0; p_bias = 0;
        p_dex = 0; p_din = 0; p_dv = 0; p_refr = 0;
        m_gex = 0; m_gin = 0; m_v = 0; m_refr = 0;
    endtask

    task automatic model_step(input int ex, input int in, input int ext);
        int drv, vinf, vn;
        m_gex = mulq(sat(m_gex + ex), p_dex);
        m_gin = mulq(sat(m_gin + in), p_din);
        e_spk = 0;
        if (m_refr != 0) begin
            m_refr--;
            e_lat = 2;
        end else begin
            e_lat = 5;
            drv  = sat(m_gex - m_gin + ext + p_bias);
            vinf = sat(p_vrest + mulq(p_gain, drv));
            vn   = sat(vinf + mulq(sat(m_v - vinf), p_dv));
            if (vn > p_thr) begin
                e_spk  = 1;
                m_v    = p_vreset;
                m_refr = p_refr;
            end else begin
                m_v = vn;
            end
        end
    endtask

    task automatic cfg_write(input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: p_thr = s16(16'(data));
            1: p_vreset = s16(16'(data));
            2: p_vrest = s16(16'(data));
            3: p_gain = s16(16'(data));
            4: p_bias = s16(16'(data));
            5: p_dex = s16(16'(data));
            6: p_din = s16(16'(data));
            7: p_dv = s16(16'(data));
            8: p_refr = data & 255;
            9: m_v = s16(16'(data));
            default: ;
        endcase
    endtask

    task automatic do_step(input logic [15:0] ex, input logic [15:0] in,
                           input logic [15:0] ext, input bit poke_start,
                           input bit poke_cfg, input string tag);
        int lat;
        int was_refr;
        was_refr = (m_refr != 0);
        model_step(s16(ex), s16(in), s16(ext));
        @(negedge clk);
        syn_ex = ex; syn_in = in; ext_in = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, {"R9 busy after start ", tag}, int'(busy), 1);
        lat = 0;
        while (done !== 1'b1 && lat < 20) begin
            @(negedge clk);
            lat++;
            start  = (lat == 1) && poke_start;
            cfg_we = (lat == 1) && poke_cfg;
            cfg_sel = 4'd0; cfg_data = 16'h8000;
        end
        start = 1'b0; cfg_we = 1'b0;
        if (was_refr)
            check(lat == e_lat, {"R8 refractory latency ", tag}, lat, e_lat);
        else
            check(lat == e_lat, {"R9 done latency ", tag}, lat, e_lat);
        check(s16(g_ex_out) == m_gex, {"R3 gex ", tag}, s16(g_ex_out), m_gex);
        check(s16(g_in_out) == m_gin, {"R3 gin ", tag}, s16(g_in_out), m_gin);
        check(s16(v_out) == m_v, {"R6 potential ", tag}, s16(v_out), m_v);
        check(int'(spike) == e_spk, {"R7 spike ", tag}, int'(spike), e_spk);
        @(negedge clk);
        check(done === 1'b0, {"R9 done pulse ", tag}, int'(done), 0);
        @(negedge clk);
        check(busy === 1'b0, {"R10 no second step ", tag}, int'(busy), 0);
    endtask

    task automatic setup_params();
        cfg_write(0, 16'h0200);
        cfg_write(1, 16'hFF00);
        cfg_write(2, 16'h0000);
        cfg_write(3, 16'h0100);
        cfg_write(4, 16'h0000);
        cfg_write(5, 16'h00C0);
        cfg_write(6, 16'h0080);
        cfg_write(7, 16'h0080);
        cfg_write(8, 2);
        cfg_write(9, 16'h0000);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check(busy === 1'b0 && done === 1'b0 && spike === 1'b0,
              "R1 control outputs low", int'({busy, done, spike}), 0);
        check(v_out === 16'h0 && g_ex_out === 16'h0 && g_in_out === 16'h0,
              "R1 state zero", s16(v_out) + s16(g_ex_out) + s16(g_in_out), 0);
    endtask

    initial begin : watchdog
        #1000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        apply_reset();
        setup_params();
        check(s16(v_out) == 0, "R2 membrane load", s16(v_out), 0);

        foreach (STIM[i])
            do_step(STIM[i][47:32], STIM[i][31:16], STIM[i][15:0], 1'b0, 1'b0, "table");

        apply_reset();
        setup_params();
        cfg_write(9, 16'h0180);
        check(s16(v_out) == 384, "R2 membrane write", s16(v_out), 384);

        // R10: start pulse during the inhibitory decay pass
        do_step(16'h0080, 16'h0040, 16'h0000, 1'b1, 1'b0, "start while busy");

        // R2: threshold write during a step is dropped; both steps use the old threshold
        do_step(16'h0040, 16'h0000, 16'h0000, 1'b0, 1'b1, "cfg while busy");
        do_step(16'h0040, 16'h0000, 16'h0000, 1'b0, 1'b0, "after cfg poke");

        // R4 and R5: saturation of sums and products
        cfg_write(0, 16'h7FFF);
        cfg_write(3, 16'h7FFF);
        cfg_write(5, 16'h7FFF);
        do_step(16'h7FFF, 16'h0000, 16'h7FFF, 1'b0, 1'b0, "R4 saturate high");
        check(s16(g_ex_out) == 32767, "R4 gex clamps", s16(g_ex_out), 32767);
        do_step(16'h8000, 16'h7FFF, 16'h8000, 1'b0, 1'b0, "R5 large negative drive");

        // R8: refractory run after a forced spike
        apply_reset();
        setup_params();
        cfg_write(9, 16'h0400);
        cfg_write(3, 16'h0200);
        do_step(16'h0400, 16'h0000, 16'h0400, 1'b0, 1'b0, "R7 forced spike");
        check(e_spk == 1, "R7 model expects spike", e_spk, 1);
        do_step(16'h0400, 16'h0000, 16'h0400, 1'b0, 1'b0, "R8 refractory 1");
        do_step(16'h0400, 16'h0000, 16'h0400, 1'b0, 1'b0, "R8 refractory 2");
        do_step(16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0, "R8 after refractory");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule